// File: doc/BRIEF.md
# FFT Stage Scaling and Saturation Unit

This unit sits behind each of the five pipeline stages of a 1024-point radix-4 FFT. It receives one complex result per cycle as two 24-bit signed parts, together with the index of the stage that produced it and a 3-bit scale code. It shifts both parts right by the number of bits that the code assigns to that stage. It rounds to nearest by adding back the most significant discarded bit. It then clamps each part to a symmetric 16-bit signed range.

Across the five stages, the scale code sets the total down-scaling to 4 plus the code value, which gives 4 to 11 bits. The largest code leaves enough headroom that a full transform cannot overflow. Each sample is accepted on a valid strobe and appears one clock later. A sticky flag records that a clamp happened, and it stays set until it is cleared.

Top module: `fft_stage_scaler`

## Requirements
- R1: When `valid_i` is sampled high on a rising edge, `valid_o` is high after that edge and the outputs carry that sample's result. When `valid_i` is low, `valid_o` is low after the edge and `re_o`/`im_o` keep their values.
- R2: The shift in bits for stages 1 to 5 (stage_i values 1..5), listed for scale codes 0..7, is: stage 1: 1,2,2,3,3,3,3,3. Stage 2: 1,1,2,2,2,2,2,2. Stage 3: 1,1,1,1,2,2,2,2. Stage 4: 1,1,1,1,1,1,2,2. Stage 5: 0,0,0,0,0,1,1,2.
- R3: With a shift of s>0, the result is the arithmetic right shift by s plus input bit s-1, computed without wrap. With a shift of 0, no rounding is applied.
- R4: A rounded result of 32767 or more outputs 32767. A result of -32767 or less outputs -32767. 16'h8000 is never output.
- R5: An all-zero input gives an all-zero output for every stage value and scale code.
- R6: `ovf_o` goes high after any edge that accepts a sample whose real or imaginary part clamps. It stays high until an edge with `ovf_clr_i` high. A clamp in the same cycle as a clear leaves the flag set.
- R7: Stage values 0, 6 and 7 apply a shift of zero.
- R8: The real and imaginary parts are scaled, rounded and clamped independently of each other.
- R9: While reset is asserted, `valid_o`, `re_o`, `im_o` and `ovf_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| stage_i | input | 3 | Stage index, 1..5 |
| scale_code_i | input | 3 | Scaling schedule code |
| re_i | input | 24 | Real part, signed |
| im_i | input | 24 | Imaginary part, signed |
| ovf_clr_i | input | 1 | Synchronous clear of overflow flag |
| valid_o | output | 1 | Output sample strobe |
| re_o | output | 16 | Scaled real part, signed |
| im_o | output | 16 | Scaled imaginary part, signed |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The assertions check several properties on every cycle:
- the one-cycle valid delay and the holding of the outputs between samples;
- that 16'h8000 never appears;
- that the overflow flag stays set until a clear;
- that zero input gives zero output;
- that an out-of-range stage passes an in-range value through unchanged.

The shift schedule for each stage and code can only be shown by the bench's scenarios. The same holds for the exact rounding of odd values, the clamp thresholds on both signs, the independence of the two parts, and set-beats-clear on the flag. The bench covers these with a swept scoreboard and directed corner samples.

// File: rtl/fft_scale_pkg.sv
package fft_scale_pkg;
  localparam int unsigned STAGE_W = 3;
  localparam int unsigned CODE_W  = 3;
  localparam int unsigned SHIFT_W = 2;

  typedef logic [SHIFT_W-1:0] shift_t;

  // shift schedule per stage; total over stages 1..5 is 4 + code
  function automatic shift_t stage_shift(input logic [STAGE_W-1:0] stage,
                                         input logic [CODE_W-1:0]  code);
    shift_t s;
    s = '0;
    unique case (stage)
      3'd1: s = (code == 3'd0) ? 2'd1 : (code < 3'd3) ? 2'd2 : 2'd3;
      3'd2: s = (code < 3'd2) ? 2'd1 : 2'd2;
      3'd3: s = (code < 3'd4) ? 2'd1 : 2'd2;
      3'd4: s = (code < 3'd6) ? 2'd1 : 2'd2;
      3'd5: s = (code < 3'd5) ? 2'd0 : (code == 3'd7) ? 2'd2 : 2'd1;
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/fft_shift_sel.sv
module fft_shift_sel
  import fft_scale_pkg::*;
(
  input  logic [STAGE_W-1:0] stage_i,
  input  logic [CODE_W-1:0]  code_i,
  output shift_t             shift_o
);
  always_comb shift_o = stage_shift(stage_i, code_i);
endmodule

// File: rtl/fft_round_sat.sv
module fft_round_sat #(
  parameter int unsigned IN_W    = 24,
  parameter int unsigned OUT_W   = 16,
  parameter int unsigned SHIFT_W = 2
) (
  input  logic signed [IN_W-1:0]  din_i,
  input  logic        [SHIFT_W-1:0] shift_i,
  output logic signed [OUT_W-1:0] dout_o,
  output logic                    sat_o
);
  localparam int unsigned EXT_W  = IN_W + 1;
  localparam int unsigned MAX_SH = (1 << SHIFT_W) - 1;
  localparam logic signed [EXT_W-1:0] POS_LIM = EXT_W'((1 << (OUT_W-1)) - 1);
  localparam logic signed [EXT_W-1:0] NEG_LIM = -POS_LIM;

  logic signed [EXT_W-1:0] ext, shd, sum;
  logic                    rbit;

  always_comb begin
    ext  = {din_i[IN_W-1], din_i};
    shd  = ext >>> shift_i;
    rbit = 1'b0;
    for (int k = 1; k <= int'(MAX_SH); k++)
      if (shift_i == SHIFT_W'(k)) rbit = din_i[k-1];
    // extra bit keeps the round-up from wrapping
    sum  = shd + $signed({{(EXT_W-1){1'b0}}, rbit});
    sat_o = 1'b0;
    if (sum > POS_LIM) begin
      dout_o = POS_LIM[OUT_W-1:0];
      sat_o  = 1'b1;
    end else if (sum < NEG_LIM) begin
      dout_o = NEG_LIM[OUT_W-1:0];
      sat_o  = 1'b1;
    end else begin
      dout_o = sum[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/fft_stage_scaler.sv
module fft_stage_scaler
  import fft_scale_pkg::*;
#(
  parameter int unsigned IN_W  = 24,
  parameter int unsigned OUT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [STAGE_W-1:0]      stage_i,
  input  logic [CODE_W-1:0]       scale_code_i,
  input  logic signed [IN_W-1:0]  re_i,
  input  logic signed [IN_W-1:0]  im_i,
  input  logic                    ovf_clr_i,
  output logic                    valid_o,
  output logic signed [OUT_W-1:0] re_o,
  output logic signed [OUT_W-1:0] im_o,
  output logic                    ovf_o
);
  localparam int unsigned N_PART = 2;

  shift_t                    shift;
  logic signed [IN_W-1:0]    part_in  [N_PART];
  logic signed [OUT_W-1:0]   part_out [N_PART];
  logic [N_PART-1:0]         part_sat;

  assign part_in[0] = re_i;
  assign part_in[1] = im_i;

  fft_shift_sel u_sel (
    .stage_i (stage_i),
    .code_i  (scale_code_i),
    .shift_o (shift)
  );

  for (genvar p = 0; p < N_PART; p++) begin : g_part
    fft_round_sat #(.IN_W(IN_W), .OUT_W(OUT_W), .SHIFT_W(SHIFT_W)) u_rs (
      .din_i   (part_in[p]),
      .shift_i (shift),
      .dout_o  (part_out[p]),
      .sat_o   (part_sat[p])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      re_o    <= '0;
      im_o    <= '0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        re_o <= part_out[0];
        im_o <= part_out[1];
      end
      // a new clamp wins over a clear in the same cycle
      ovf_o <= (ovf_o & ~ovf_clr_i) | (valid_i & (|part_sat));
    end
  end
endmodule

// File: rtl/fft_stage_scaler_chk.sv
module fft_stage_scaler_chk #(
  parameter int unsigned IN_W  = 24,
  parameter int unsigned OUT_W = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic [2:0]              stage_i,
  input logic [2:0]              scale_code_i,
  input logic signed [IN_W-1:0]  re_i,
  input logic signed [IN_W-1:0]  im_i,
  input logic                    ovf_clr_i,
  input logic                    valid_o,
  input logic signed [OUT_W-1:0] re_o,
  input logic signed [OUT_W-1:0] im_o,
  input logic                    ovf_o
);
  localparam logic signed [IN_W-1:0] LIM = IN_W'((1 << (OUT_W-1)) - 1);

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  a_r1_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (valid_o == $past(valid_i)));

  a_r1_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(valid_i)) |-> ($stable(re_o) && $stable(im_o)));

  a_r4_no_min_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (re_o != {1'b1, {(OUT_W-1){1'b0}}} && im_o != {1'b1, {(OUT_W-1){1'b0}}}));

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(ovf_o) && !$past(ovf_clr_i)) |-> ovf_o);

  a_r5_zero_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i) && $past(re_i) == '0 && $past(im_i) == '0)
      |-> (re_o == '0 && im_o == '0));

  a_r7_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i) && ($past(stage_i) == 3'd0 || $past(stage_i) > 3'd5)
      && $past(re_i) <= LIM && $past(re_i) >= -LIM)
      |-> (re_o == $past(re_i[OUT_W-1:0])));
endmodule

bind fft_stage_scaler fft_stage_scaler_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .stage_i      (stage_i),
  .scale_code_i (scale_code_i),
  .re_i         (re_i),
  .im_i         (im_i),
  .ovf_clr_i    (ovf_clr_i),
  .valid_o      (valid_o),
  .re_o         (re_o),
  .im_o         (im_o),
  .ovf_o        (ovf_o)
);

// File: tb/tb_fft_stage_scaler.sv
module tb_fft_stage_scaler;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               valid_i = 1'b0;
  logic [2:0]         stage_i = '0;
  logic [2:0]         code_i = '0;
  logic signed [23:0] re_i = '0;
  logic signed [23:0] im_i = '0;
  logic               clr_i = 1'b0;
  logic               valid_o;
  logic signed [15:0] re_o, im_o;
  logic               ovf_o;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic signed [15:0] re;
    logic signed [15:0] im;
    string              tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  fft_stage_scaler dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .stage_i(stage_i),
    .scale_code_i(code_i), .re_i(re_i), .im_i(im_i), .ovf_clr_i(clr_i),
    .valid_o(valid_o), .re_o(re_o), .im_o(im_o), .ovf_o(ovf_o)
  );

  int sh1[8] = '{1,2,2,3,3,3,3,3};
  int sh2[8] = '{1,1,2,2,2,2,2,2};
  int sh3[8] = '{1,1,1,1,2,2,2,2};
  int sh4[8] = '{1,1,1,1,1,1,2,2};
  int sh5[8] = '{0,0,0,0,0,1,1,2};

  function automatic int shift_of(int st, int cd);
    case (st)
      1: return sh1[cd];
      2: return sh2[cd];
      3: return sh3[cd];
      4: return sh4[cd];
      5: return sh5[cd];
      default: return 0;
    endcase
  endfunction

  function automatic int model(int st, int cd, logic signed [23:0] x);
    int v, s, r;
    v = int'(x);
    s = shift_of(st, cd);
    r = v >>> s;
    if (s > 0) r = r + ((v >>> (s - 1)) & 1);
    if (r >= 32767) r = 32767;
    if (r <= -32767) r = -32767;
    return r;
  endfunction

  function automatic bit will_sat(int st, int cd, logic signed [23:0] x);
    int v, s, r;
    v = int'(x);
    s = shift_of(st, cd);
    r = v >>> s;
    if (s > 0) r = r + ((v >>> (s - 1)) & 1);
    return (r > 32767) || (r < -32767);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(int st, int cd, logic signed [23:0] re, logic signed [23:0] im, string tag);
    exp_t e;
    @(negedge clk);
    valid_i = 1'b1;
    stage_i = 3'(st);
    code_i  = 3'(cd);
    re_i    = re;
    im_i    = im;
    e.re  = 16'(model(st, cd, re));
    e.im  = 16'(model(st, cd, im));
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      clr_i   = 1'b0;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (q.size() == 0) begin
        check(1'b0, "R1 unexpected valid_o", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(re_o == e.re, {e.tag, " re"}, int'(re_o), int'(e.re));
        check(im_o == e.im, {e.tag, " im"}, int'(im_o), int'(e.im));
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int x;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(valid_o == 1'b0 && re_o == 0 && im_o == 0 && ovf_o == 1'b0, "R9 reset",
          int'(re_o) + int'(valid_o) + int'(ovf_o), 0);
    rst_n = 1'b1;
    idle(2);

    // R5 zero in for all stages and codes
    for (int st = 0; st < 8; st++)
      for (int cd = 0; cd < 8; cd++)
        send(st, cd, 24'sd0, 24'sd0, "R5 zero");
    idle(2);

    // R2 schedule sweep with a value showing every shift distinctly
    for (int st = 1; st <= 5; st++)
      for (int cd = 0; cd < 8; cd++)
        send(st, cd, 24'sd4096, -24'sd8000, "R2 schedule");
    idle(2);

    // R3 rounding corners
    send(1, 0, 24'sd3, -24'sd3, "R3 round s1");
    send(1, 3, 24'sd12, 24'sd11, "R3 round s3");
    send(1, 3, -24'sd12, -24'sd13, "R3 round neg s3");
    send(5, 0, 24'sd7, -24'sd7, "R3 shift0 no round");
    send(5, 7, 24'sd6, 24'sd5, "R3 round s2");
    idle(2);

    // R7 out-of-range stage passes through
    send(0, 7, 24'sd1235, -24'sd1, "R7 stage0");
    send(6, 3, -24'sd32767, 24'sd32767, "R7 stage6");
    send(7, 5, 24'sd99, 24'sd100, "R7 stage7");
    idle(2);

    // R4 clamp thresholds, R8 independent parts
    send(5, 0, 24'sd32767, 24'sd32768, "R4 pos edge");
    send(5, 0, -24'sd32767, -24'sd32768, "R4 neg edge");
    send(1, 0, 24'sd65534, -24'sd65534, "R4 round at edge");
    send(1, 0, 24'sd8388607, 24'sd5, "R8 re sat im small");
    send(2, 2, -24'sd17, -24'sd8388608, "R8 im sat re small");
    idle(1);
    // R6 flag set by the clamp above
    check(ovf_o == 1'b1, "R6 set", int'(ovf_o), 1);
    idle(3);
    check(ovf_o == 1'b1, "R6 sticky", int'(ovf_o), 1);
    // R1 outputs hold while idle
    check(re_o == -16'sd4 && im_o == -16'sd32767, "R1 hold", int'(re_o), -4);
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
    check(ovf_o == 1'b0, "R6 clear", int'(ovf_o), 0);
    send(3, 1, 24'sd1000, 24'sd1000, "R6 no sat");
    idle(1);
    check(ovf_o == 1'b0, "R6 no set", int'(ovf_o), 0);
    // R6 clamp beats clear in the same cycle
    send(5, 0, 24'sd40000, 24'sd0, "R6 set vs clr");
    clr_i = 1'b1;
    idle(1);
    check(ovf_o == 1'b1, "R6 set wins", int'(ovf_o), 1);

    // R8 mixed random samples
    for (int i = 0; i < 200; i++) begin
      x = int'($urandom_range(0, 200000)) - 100000;
      send(int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
           24'(x), 24'(x * 3 + 11), "R8 random");
    end
    idle(3);
    check(q.size() == 0, "R1 drained", q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule